// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a separate, word-organised internal address space through just two host registers. A host write to the control register starts one internal access. The address sits in the low field of that write, and a direction flag selects read or write. For a write, the host first places the payload in the data register. When the access starts, the block raises a busy bit and presents a request to the internal side. It then waits for a single-cycle acknowledge, which may arrive after any number of cycles. On a read, the acknowledge carries the result, and the block latches it into the data register.

Software polls the busy bit in the control register until it reads zero, then fetches the result from the data register. Internal addresses are byte addresses of 32-bit words, so a software loop steps through consecutive words by adding 4. The block holds no timeout of its own.

Top module: `ind_access_bridge`

## Requirements
- R1: After reset the control register reads 0, the data register reads 0, and `int_req` is low.
- R2: A control write (`host_sel`=0) with bit 30 clear while idle starts a read: on the next cycle `int_req`=1, `int_we`=0, and `int_addr` equals the written address with bits [1:0] forced to 0.
- R3: A control write with bit 30 set while idle starts a write: on the next cycle `int_req`=1, `int_we`=1, and `int_wdata` equals the data register (`host_sel`=1) contents.
- R4: Busy and `int_req` stay high, with `int_addr` unchanged, for every cycle without `int_ack`. The cycle after an `int_ack` cycle, both are low.
- R5: On a read, the `int_rdata` value present with `int_ack` reads back from the data register from the next cycle on.
- R6: A write access leaves the data register holding the value the host staged.
- R7: A control write while busy is ignored: address, direction flag and busy are unchanged and no new access starts.
- R8: A data register write while busy is ignored, so `int_wdata` stays stable during a write access.
- R9: The control register reads back the address in bits [ADDR_W-1:0] (bits [1:0] always 0), the direction flag in bit 30 and the live busy bit in bit 31. Bit 31 is read-only, and the value written to it has no effect.
- R10: `int_ack` while idle changes neither the registers nor `int_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Read value of the selected register (combinational) |
| int_req | output | 1 | Internal request, held until acknowledged |
| int_addr | output | ADDR_W | Internal byte address, word aligned |
| int_we | output | 1 | Internal write enable |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Single-cycle internal acknowledge |
| int_rdata | input | 32 | Internal read data, valid with `int_ack` |

## Verification
A host write taken at a rising edge shows on the request outputs and on the busy bit from the following cycle. The bench therefore samples one falling edge after the write strobe's edge. An acknowledge taken at an edge clears busy and updates the data register by that same edge, so the result is read at the very next falling edge. Acknowledge latency is swept from zero to four cycles. Ignored writes are injected during the waiting cycles, and their effect is checked at the ports before the acknowledge arrives.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int REG_W    = 32;
  localparam int BUSY_BIT = 31;
  localparam int DIR_BIT  = 30;
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  // Clear the byte offset inside a 4-byte word.
  function automatic logic [REG_W-1:0] word_align(input logic [REG_W-1:0] a);
    return a & ~REG_W'(3);
  endfunction

  // Assemble the control register image from its fields.
  function automatic logic [REG_W-1:0] ctrl_image(input logic [REG_W-1:0] addr,
                                                  input logic dir_wr,
                                                  input logic busy);
    logic [REG_W-1:0] v;
    v = addr;
    v[DIR_BIT]  = dir_wr;
    v[BUSY_BIT] = busy;
    return v;
  endfunction
endpackage

// File: rtl/bridge_access_seq.sv
module bridge_access_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic int_ack,
  output logic busy,
  output logic done
);
  logic busy_q;

  assign busy = busy_q;
  assign done = busy_q && int_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
    else if (done) busy_q <= 1'b0;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R2
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !int_ack |=> busy_q); // R4
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R4
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && int_ack && !start |=> !busy_q); // R10
endmodule

// File: rtl/bridge_host_regs.sv
module bridge_host_regs
  import ind_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [REG_W-1:0]  done_rdata,
  output logic              start,
  output logic [ADDR_W-1:0] ctrl_addr,
  output logic              ctrl_wr_dir,
  output logic [REG_W-1:0]  data_val
);
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  logic [REG_W-1:0]  data_q;
  logic [REG_W-1:0]  aligned_w;
  logic              ctrl_hit;
  logic              data_hit;
  logic              capture;

  assign aligned_w = word_align(host_wdata);
  assign ctrl_hit  = host_wr && (host_sel == SEL_CTRL);
  assign data_hit  = host_wr && (host_sel == SEL_DATA);
  assign start     = ctrl_hit && !busy;
  assign capture   = done && !dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else if (start) begin
      addr_q <= aligned_w[ADDR_W-1:0];
      dir_q  <= host_wdata[DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (capture) data_q <= done_rdata;
    else if (data_hit && !busy) data_q <= host_wdata;
  end

  assign ctrl_addr   = addr_q;
  assign ctrl_wr_dir = dir_q;
  assign data_val    = data_q;
  assign host_rdata  = (host_sel == SEL_CTRL) ? ctrl_image(REG_W'(addr_q), dir_q, busy) : data_q;

  AST_CTRL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl_hit |=> $stable(addr_q) && $stable(dir_q)); // R7
  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_hit && !capture |=> $stable(data_q)); // R8
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> data_q == $past(done_rdata)); // R5
  AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done && dir_q |=> $stable(data_q)); // R6
endmodule

// File: rtl/ind_access_bridge.sv
module ind_access_bridge
  import ind_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              int_req,
  output logic [ADDR_W-1:0] int_addr,
  output logic              int_we,
  output logic [31:0]       int_wdata,
  input  logic              int_ack,
  input  logic [31:0]       int_rdata
);
  logic start_evt;
  logic done_evt;
  logic busy_w;

  bridge_access_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .int_ack (int_ack),
    .busy    (busy_w),
    .done    (done_evt)
  );

  bridge_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .busy        (busy_w),
    .done        (done_evt),
    .done_rdata  (int_rdata),
    .start       (start_evt),
    .ctrl_addr   (int_addr),
    .ctrl_wr_dir (int_we),
    .data_val    (int_wdata)
  );

  assign int_req = busy_w;

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_addr[1:0] == 2'b00); // R9
  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ack |=> $stable(int_addr) && $stable(int_we)); // R4
endmodule

// File: tb/test_ind_access_bridge.sv
module test_ind_access_bridge;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          host_sel = 1'b0;
  logic          host_wr = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          int_req;
  logic [AW-1:0] int_addr;
  logic          int_we;
  logic [31:0]   int_wdata;
  logic          int_ack = 1'b0;
  logic [31:0]   int_rdata = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  ind_access_bridge #(.ADDR_W(AW)) i_ind_access_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .int_req(int_req),
    .int_addr(int_addr), .int_we(int_we), .int_wdata(int_wdata),
    .int_ack(int_ack), .int_rdata(int_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] aligned(input logic [AW-1:0] a);
    return 32'((a >> 2) * 4);
  endfunction

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return (a * 32'h0001_9E37) ^ 32'hC3A5_0000;
  endfunction

  function automatic logic [31:0] wr_pattern(input logic [31:0] a);
    return ~(a << 8) ^ 32'h0000_1234;
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic [31:0] a, input bit wr, input bit bsy);
    return (bsy ? 32'h8000_0000 : 32'h0) + (wr ? 32'h4000_0000 : 32'h0) + a;
  endfunction

  task automatic host_put(input logic sel, input logic [31:0] val);
    @(negedge clk);
    host_sel = sel; host_wdata = val; host_wr = 1'b1;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] v);
    host_sel = sel;
    #1 v = host_rdata;
  endtask

  task automatic do_access(input logic [AW-1:0] a, input bit wr, input int lat,
                           input logic [31:0] wval, input bit poke_busy);
    logic [31:0] v;
    logic [31:0] ctl;
    string tag;
    tag = wr ? "R3" : "R2";
    if (wr) host_put(1'b1, wval);
    ctl = 32'(a) | (wr ? 32'h4000_0000 : 32'h0) | (poke_busy ? 32'h8000_0000 : 32'h0);
    host_put(1'b0, ctl);
    @(negedge clk);
    check(tag, 32'(int_req), 32'd1);
    check(tag, 32'(int_addr), aligned(a));
    check(tag, 32'(int_we), 32'(wr));
    if (wr) check("R3", int_wdata, wval);
    read_reg(1'b0, v);
    check("R9", v, exp_ctrl(aligned(a), wr, 1'b1));
    for (int i = 0; i < lat; i++) begin
      if (i == 0) begin
        host_sel = 1'b0; host_wdata = 32'(~a) ^ 32'h4000_0000; host_wr = 1'b1;
      end else if (i == 1) begin
        host_sel = 1'b1; host_wdata = 32'hDEAD_BEEF; host_wr = 1'b1;
      end
      @(posedge clk);
      #1 host_wr = 1'b0;
      @(negedge clk);
      check("R4", 32'(int_req), 32'd1);
      check("R4", 32'(int_addr), aligned(a));
      read_reg(1'b0, v);
      check("R7", v, exp_ctrl(aligned(a), wr, 1'b1));
      if (wr) check("R8", int_wdata, wval);
    end
    int_rdata = wr ? 32'hFFFF_0000 : rd_pattern(aligned(a));
    int_ack = 1'b1;
    @(posedge clk);
    #1 int_ack = 1'b0; int_rdata = '0;
    @(negedge clk);
    check("R4", 32'(int_req), 32'd0);
    read_reg(1'b0, v);
    check("R4", 32'(v[31]), 32'd0);
    read_reg(1'b1, v);
    if (wr) check("R6", v, wval);
    else check("R5", v, rd_pattern(aligned(a)));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(int_req), 32'd0);
    read_reg(1'b0, v);
    check("R1", v, 32'd0);
    read_reg(1'b1, v);
    check("R1", v, 32'd0);
    rst_n = 1'b1;

    @(negedge clk);
    int_ack = 1'b1; int_rdata = 32'h5555_AAAA;
    @(posedge clk);
    #1 int_ack = 1'b0; int_rdata = '0;
    @(negedge clk);
    check("R10", 32'(int_req), 32'd0);
    read_reg(1'b1, v);
    check("R10", v, 32'd0);
    read_reg(1'b0, v);
    check("R10", v, 32'd0);

    for (int w = 0; w < (1 << AW) / 4; w++) begin
      do_access(AW'(w * 4), 1'b1, w % 5, wr_pattern(32'(w * 4)), (w % 8) == 0);
    end
    for (int w = 0; w < (1 << AW) / 4; w++) begin
      do_access(AW'(w * 4 + (w % 4)), 1'b0, (w + 2) % 5, 32'd0, (w % 8) == 3);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule